// File: doc/BRIEF.md
# Clock Source Lock and Slip Monitor

This block watches eleven external sample-clock sources and the source that is currently selected. Each source supplies an asynchronous lock level and a synchronous slip pulse. The block resynchronises the lock levels and shows them live in an extended status word. Slip pulses are collected into sticky flags in the upper half of that same word. The flags persist until software reads the word with a single-word access. A block read returns the flags and leaves them intact.

A second status word reports two things: whether the selected source is locked, and the nominal sample-rate code supplied by the rate logic. Two single-cycle event pulses feed a notification unit. One fires on any change of any source's lock bit. The other fires when the lock state of the selected source changes. Slip activity never raises an event.

Top module: `clk_src_monitor`

## Requirements
- R1: Lock bits occupy ext_status_o bits 0 to 10 in the source order AES1, AES2, AES3, AES4, ADAT, TDIF, ARX1, ARX2, ARX3, ARX4, word clock. Each lock input passes through two flops, so a level change sampled at one rising edge appears after the following edge.
- R2: A slip pulse on source i sets ext_status_o bit 16+i at the next rising edge, in the same source order as the lock bits. The bit then stays set.
- R3: A single-word read is rd_stb_i=1 with rd_block_i=0. It returns the current word during its cycle and clears every slip bit at the closing edge.
- R4: A block read is rd_stb_i=1 with rd_block_i=1. It leaves all slip bits unchanged.
- R5: A slip pulse in the same cycle as a single-word read leaves its own bit set after the read. Bits without a pulse are cleared.
- R6: Slip pulses raise neither ext_evt_o nor lock_evt_o.
- R7: ext_evt_o is high for exactly the first cycle in which ext_status_o shows a changed lock bit.
- R8: status_o bit 0 gives the lock bit of the source index held in cur_src_i, registered one cycle. Indexes 0 to 10 follow the R1 order. Any index of 11 or more (the internal clock) reads as locked.
- R9: status_o bits 15:8 give rate_code_i registered one cycle. The codes are 0=32k, 1=44.1k, 2=48k, 3=88.2k, 4=96k, 5=176.4k, 6=192k and 0x0A=none.
- R10: lock_evt_o is high for exactly the first cycle in which status_o bit 0 differs from the cycle before. This includes a change caused by switching sources.
- R11: After reset with a source index below 11, every output is zero. Unused bits of both words are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lock_i | input | 11 | Asynchronous lock level per source |
| src_slip_i | input | 11 | Synchronous slip pulse per source |
| cur_src_i | input | 4 | Selected source index (11 and above = internal) |
| rate_code_i | input | 8 | Nominal rate code |
| rd_stb_i | input | 1 | Extended status word is being read this cycle |
| rd_block_i | input | 1 | The read is part of a block read |
| ext_status_o | output | 32 | Live lock bits and sticky slip flags |
| status_o | output | 32 | Selected-source lock and rate code |
| ext_evt_o | output | 1 | Pulse on any lock bit change |
| lock_evt_o | output | 1 | Pulse on selected-source lock change |

## Verification
The bench targets the cycle in which a slip pulse meets a clearing read. A design that let the clear win would lose that slip. It also checks block reads, because a design that cleared on every read strobe would erase flags that software never consumed. It switches between sources with different lock states, including the internal indexes. A design that watched only lock edges would miss the switch event, and one that bounded the index wrongly would report the internal clock as unlocked. Slip bursts with steady lock inputs expose any design that lets slips leak into the event outputs.

// File: rtl/clkmon_pkg.sv
// Shared constants for the clock source monitor.
// Assumes a 32-bit register word with slip flags placed above the lock flags.
package clkmon_pkg;
    localparam int unsigned SRC_COUNT   = 11;
    localparam int unsigned SLIP_BASE   = 16;
    localparam int unsigned SYNC_DEPTH  = 2;
    localparam int unsigned SEL_BITS    = 4;
    localparam int unsigned RATE_BITS   = 8;
    localparam int unsigned WORD_BITS   = 32;
    localparam int unsigned RATE_BASE   = 8;
endpackage

// File: rtl/clkmon_sync.sv
// Multi-stage synchroniser for a vector of asynchronous level inputs.
// Assumes each bit is an independent slow level; no bus coherency is implied.
module clkmon_sync #(
    parameter int unsigned WIDTH  = 11,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage captures the raw asynchronous levels.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= async_i;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        // Each further stage lowers the metastability risk.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
        end
    end

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/clkmon_slip.sv
// Sticky slip flags cleared by a single-word read.
// Assumes slip pulses are already synchronous to clk. A pulse that coincides
// with a clearing read survives that read.
module clkmon_slip #(
    parameter int unsigned WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] slip_i,
    input  logic             rd_stb_i,
    input  logic             rd_block_i,
    output logic [WIDTH-1:0] flags_o
);
    logic             clear_rd;
    logic [WIDTH-1:0] flags_q;

    assign clear_rd = rd_stb_i & ~rd_block_i;

    // Accumulate slips; a single-word read discards all but the new ones.
    always_ff @(posedge clk) begin
        if (!rst_n)        flags_q <= '0;
        else if (clear_rd) flags_q <= slip_i;
        else               flags_q <= flags_q | slip_i;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/clkmon_evt.sv
// Change detection on synchronised lock bits and on the selected source's lock.
// Assumes SEL_W wide enough to index every source; indexes past the last
// source stand for the internal clock, which is always locked.
module clkmon_evt #(
    parameter int unsigned NUM_SRC = 11,
    parameter int unsigned SEL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] lock_sync_i,
    input  logic [SEL_W-1:0]   cur_src_i,
    output logic               cur_lock_o,
    output logic               any_evt_o,
    output logic               cur_evt_o
);
    localparam int unsigned SLOTS = 1 << SEL_W;
    localparam int unsigned PAD   = SLOTS - NUM_SRC;

    logic [SEL_W-1:0]   src_q;
    logic [NUM_SRC-1:0] lock_prev;
    logic               cur_prev;
    logic [SLOTS-1:0]   padded;

    if (PAD > 0) begin : g_pad
        assign padded = {{PAD{1'b1}}, lock_sync_i};
    end else begin : g_nopad
        assign padded = lock_sync_i;
    end

    // Register the selection so a switch acts on a clean edge.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= cur_src_i;
    end

    assign cur_lock_o = padded[src_q];

    // Remember last cycle's lock picture for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_prev <= '0;
            cur_prev  <= 1'b0;
        end else begin
            lock_prev <= lock_sync_i;
            cur_prev  <= cur_lock_o;
        end
    end

    assign any_evt_o = |(lock_sync_i ^ lock_prev);
    assign cur_evt_o = cur_lock_o ^ cur_prev;
endmodule

// File: rtl/clk_src_monitor.sv
// Top of the clock source monitor: packs live lock bits and sticky slip
// flags into the extended word, selected-source lock and rate into the status
// word, and drives the two notification pulses.
// Assumes rate_code_i is synchronous and slip pulses are one clk wide.
module clk_src_monitor #(
    parameter int unsigned NUM_SRC     = clkmon_pkg::SRC_COUNT,
    parameter int unsigned SLIP_LSB    = clkmon_pkg::SLIP_BASE,
    parameter int unsigned SYNC_STAGES = clkmon_pkg::SYNC_DEPTH,
    parameter int unsigned SEL_W       = clkmon_pkg::SEL_BITS,
    parameter int unsigned RATE_W      = clkmon_pkg::RATE_BITS,
    parameter int unsigned WORD_W      = clkmon_pkg::WORD_BITS,
    parameter int unsigned RATE_LSB    = clkmon_pkg::RATE_BASE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lock_i,
    input  logic [NUM_SRC-1:0] src_slip_i,
    input  logic [SEL_W-1:0]   cur_src_i,
    input  logic [RATE_W-1:0]  rate_code_i,
    input  logic               rd_stb_i,
    input  logic               rd_block_i,
    output logic [WORD_W-1:0]  ext_status_o,
    output logic [WORD_W-1:0]  status_o,
    output logic               ext_evt_o,
    output logic               lock_evt_o
);
    logic [NUM_SRC-1:0] lock_sync;
    logic [NUM_SRC-1:0] slip_flags;
    logic [RATE_W-1:0]  rate_q;
    logic               cur_lock;

    clkmon_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_lock_i),
        .sync_o  (lock_sync)
    );

    clkmon_slip #(.WIDTH(NUM_SRC)) u_slip (
        .clk        (clk),
        .rst_n      (rst_n),
        .slip_i     (src_slip_i),
        .rd_stb_i   (rd_stb_i),
        .rd_block_i (rd_block_i),
        .flags_o    (slip_flags)
    );

    clkmon_evt #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_sync_i (lock_sync),
        .cur_src_i   (cur_src_i),
        .cur_lock_o  (cur_lock),
        .any_evt_o   (ext_evt_o),
        .cur_evt_o   (lock_evt_o)
    );

    // Hold the nominal rate code for the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) rate_q <= '0;
        else        rate_q <= rate_code_i;
    end

    // Pack lock and slip fields into the extended word.
    always_comb begin
        ext_status_o = '0;
        ext_status_o[NUM_SRC-1:0]         = lock_sync;
        ext_status_o[SLIP_LSB +: NUM_SRC] = slip_flags;
    end

    // Pack selected-source lock and rate into the status word.
    always_comb begin
        status_o = '0;
        status_o[0]                 = cur_lock;
        status_o[RATE_LSB +: RATE_W] = rate_q;
    end
endmodule

// File: rtl/clk_src_monitor_chk.sv
// Property checker for clk_src_monitor, attached by bind.
module clk_src_monitor_chk #(
    parameter int unsigned NUM_SRC  = 11,
    parameter int unsigned SLIP_LSB = 16,
    parameter int unsigned RATE_W   = 8,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned RATE_LSB = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_slip_i,
    input logic [RATE_W-1:0]  rate_code_i,
    input logic               rd_stb_i,
    input logic               rd_block_i,
    input logic [WORD_W-1:0]  ext_status_o,
    input logic [WORD_W-1:0]  status_o,
    input logic               ext_evt_o,
    input logic               lock_evt_o
);
    logic [NUM_SRC-1:0] slipf;
    logic [NUM_SRC-1:0] lockf;
    logic [WORD_W-1:0]  ext_mask;
    logic [WORD_W-1:0]  st_mask;

    assign slipf = ext_status_o[SLIP_LSB +: NUM_SRC];
    assign lockf = ext_status_o[NUM_SRC-1:0];

    always_comb begin
        ext_mask = '0;
        ext_mask[NUM_SRC-1:0]         = '1;
        ext_mask[SLIP_LSB +: NUM_SRC] = '1;
        st_mask = '0;
        st_mask[0]                   = 1'b1;
        st_mask[RATE_LSB +: RATE_W]  = '1;
    end

    p_slip_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_slip_i) |=> ((slipf & $past(src_slip_i)) == $past(src_slip_i)));

    p_slip_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && !rd_block_i) |=> (slipf == $past(src_slip_i)));

    p_slip_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb_i && !rd_block_i) |=> ((slipf & $past(slipf)) == $past(slipf)));

    p_ext_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_evt_o == (lockf != $past(lockf)));

    p_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (status_o[RATE_LSB +: RATE_W] == $past(rate_code_i)));

    p_lock_evt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_evt_o == (status_o[0] != $past(status_o[0])));

    p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((ext_status_o & ~ext_mask) == '0) && ((status_o & ~st_mask) == '0));
endmodule

bind clk_src_monitor clk_src_monitor_chk #(
    .NUM_SRC  (NUM_SRC),
    .SLIP_LSB (SLIP_LSB),
    .RATE_W   (RATE_W),
    .WORD_W   (WORD_W),
    .RATE_LSB (RATE_LSB)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_slip_i   (src_slip_i),
    .rate_code_i  (rate_code_i),
    .rd_stb_i     (rd_stb_i),
    .rd_block_i   (rd_block_i),
    .ext_status_o (ext_status_o),
    .status_o     (status_o),
    .ext_evt_o    (ext_evt_o),
    .lock_evt_o   (lock_evt_o)
);

// File: tb/test_clk_src_monitor.sv
// Scoreboard bench: the driver applies one cycle of stimulus, predicts the
// outputs after the next edge from the requirements and queues them; the
// monitor compares just after each edge.
module test_clk_src_monitor;
    localparam int PERIOD = 10;

    typedef struct {
        logic [31:0] ext;
        logic [31:0] st;
        logic        ee;
        logic        le;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] src_lock_i = '0;
    logic [10:0] src_slip_i = '0;
    logic [3:0]  cur_src_i = '0;
    logic [7:0]  rate_code_i = '0;
    logic        rd_stb_i = 1'b0;
    logic        rd_block_i = 1'b0;
    logic [31:0] ext_status_o;
    logic [31:0] status_o;
    logic        ext_evt_o;
    logic        lock_evt_o;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    // Bench-side expectation state, derived from the requirements.
    logic [10:0] m_s1 = '0, m_s2 = '0, m_slip = '0;
    logic [3:0]  m_src = '0;
    logic [7:0]  m_rate = '0;

    clk_src_monitor i_clk_src_monitor (
        .clk(clk), .rst_n(rst_n), .src_lock_i(src_lock_i), .src_slip_i(src_slip_i),
        .cur_src_i(cur_src_i), .rate_code_i(rate_code_i), .rd_stb_i(rd_stb_i),
        .rd_block_i(rd_block_i), .ext_status_o(ext_status_o), .status_o(status_o),
        .ext_evt_o(ext_evt_o), .lock_evt_o(lock_evt_o)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic cur_lock(input logic [10:0] v, input logic [3:0] s);
        return (s < 4'd11) ? v[s] : 1'b1;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Driver: one cycle of stimulus plus its predicted result.
    task automatic cyc(input logic [10:0] lk, input logic [10:0] sl, input logic [3:0] src,
                       input logic [7:0] rt, input logic rd, input logic blk, input string tag);
        exp_t e;
        logic [10:0] n_s2;
        logic [10:0] n_slip;
        @(negedge clk);
        src_lock_i = lk; src_slip_i = sl; cur_src_i = src;
        rate_code_i = rt; rd_stb_i = rd; rd_block_i = blk;
        n_s2   = m_s1;
        n_slip = (rd && !blk) ? sl : (m_slip | sl);
        e.ext  = {5'b0, n_slip, 5'b0, n_s2};
        e.st   = {16'b0, rt, 7'b0, cur_lock(n_s2, src)};
        e.ee   = (n_s2 != m_s2);
        e.le   = cur_lock(n_s2, src) != cur_lock(m_s2, m_src);
        e.tag  = tag;
        q.push_back(e);
        m_s1 = lk; m_s2 = n_s2; m_slip = n_slip; m_src = src; m_rate = rt;
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (ext_status_o !== e.ext || status_o !== e.st ||
                    ext_evt_o !== e.ee || lock_evt_o !== e.le) begin
                    errors++;
                    $display("FAIL %s: got ext=%h st=%h ee=%b le=%b, expected ext=%h st=%h ee=%b le=%b",
                             e.tag, ext_status_o, status_o, ext_evt_o, lock_evt_o,
                             e.ext, e.st, e.ee, e.le);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        logic [10:0] lk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: reset state.
        checks++;
        if (ext_status_o !== '0 || status_o !== '0 || ext_evt_o !== 1'b0 || lock_evt_o !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset: got ext=%h st=%h ee=%b le=%b, expected all zero",
                     ext_status_o, status_o, ext_evt_o, lock_evt_o);
        end

        // R1 R7: walk one lock bit through each source position.
        for (int i = 0; i < 11; i++) begin
            lk = 11'(1) << i;
            cyc(lk, '0, 4'd0, 8'd2, 1'b0, 1'b0, "R1 R7 walk");
            cyc(lk, '0, 4'd0, 8'd2, 1'b0, 1'b0, "R1 R7 walk");
            cyc(lk, '0, 4'd0, 8'd2, 1'b0, 1'b0, "R1 R7 walk");
        end
        cyc(11'h5A5, '0, 4'd0, 8'd2, 1'b0, 1'b0, "R1 R7 pattern");
        cyc(11'h7FF, '0, 4'd0, 8'd2, 1'b0, 1'b0, "R1 R7 back-to-back");
        repeat (3) cyc(11'h7FF, '0, 4'd0, 8'd2, 1'b0, 1'b0, "R1 R7 settle");

        // R2 R6: slips set sticky bits and never raise events.
        cyc(11'h7FF, 11'h001, 4'd0, 8'd2, 1'b0, 1'b0, "R2 R6 slip0");
        cyc(11'h7FF, 11'h400, 4'd0, 8'd2, 1'b0, 1'b0, "R2 R6 slip10");
        cyc(11'h7FF, 11'h0F0, 4'd0, 8'd2, 1'b0, 1'b0, "R2 R6 burst");
        cyc(11'h7FF, '0, 4'd0, 8'd2, 1'b0, 1'b0, "R2 hold");

        // R4: block reads keep the flags.
        cyc(11'h7FF, '0, 4'd0, 8'd2, 1'b1, 1'b1, "R4 block read");
        cyc(11'h7FF, '0, 4'd0, 8'd2, 1'b1, 1'b1, "R4 block read");
        cyc(11'h7FF, '0, 4'd0, 8'd2, 1'b0, 1'b0, "R4 after");

        // R3: single-word read clears.
        cyc(11'h7FF, '0, 4'd0, 8'd2, 1'b1, 1'b0, "R3 clear read");
        cyc(11'h7FF, '0, 4'd0, 8'd2, 1'b0, 1'b0, "R3 after clear");

        // R5: slip during a clearing read survives it.
        cyc(11'h7FF, 11'h022, 4'd0, 8'd2, 1'b0, 1'b0, "R5 preset");
        cyc(11'h7FF, 11'h008, 4'd0, 8'd2, 1'b1, 1'b0, "R5 collide");
        cyc(11'h7FF, '0, 4'd0, 8'd2, 1'b0, 1'b0, "R5 after");
        cyc(11'h7FF, '0, 4'd0, 8'd2, 1'b1, 1'b0, "R3 R5 final clear");

        // R8 R10: alternate lock pattern, sweep the selection incl. internal.
        cyc(11'h155, '0, 4'd0, 8'd2, 1'b0, 1'b0, "R8 R10 prep");
        cyc(11'h155, '0, 4'd0, 8'd2, 1'b0, 1'b0, "R8 R10 prep");
        for (int s = 0; s < 14; s++) begin
            cyc(11'h155, '0, 4'(s), 8'd2, 1'b0, 1'b0, "R8 R10 select");
            cyc(11'h155, '0, 4'(s), 8'd2, 1'b0, 1'b0, "R8 R10 select");
        end

        // R10: toggle selected vs unselected source.
        cyc(11'h155, '0, 4'd2, 8'd2, 1'b0, 1'b0, "R10 sel2");
        repeat (3) cyc(11'h151, '0, 4'd2, 8'd2, 1'b0, 1'b0, "R10 selected drops");
        repeat (3) cyc(11'h159, '0, 4'd2, 8'd2, 1'b0, 1'b0, "R10 R7 other toggles");

        // R9: rate codes.
        cyc(11'h159, '0, 4'd2, 8'h00, 1'b0, 1'b0, "R9 32k");
        cyc(11'h159, '0, 4'd2, 8'h01, 1'b0, 1'b0, "R9 44k1");
        cyc(11'h159, '0, 4'd2, 8'h03, 1'b0, 1'b0, "R9 88k2");
        cyc(11'h159, '0, 4'd2, 8'h04, 1'b0, 1'b0, "R9 96k");
        cyc(11'h159, '0, 4'd2, 8'h05, 1'b0, 1'b0, "R9 176k4");
        cyc(11'h159, '0, 4'd2, 8'h06, 1'b0, 1'b0, "R9 192k");
        cyc(11'h159, '0, 4'd2, 8'h0A, 1'b0, 1'b0, "R9 none");
        cyc(11'h159, '0, 4'd2, 8'h0A, 1'b0, 1'b0, "R9 hold");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule